// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register, either a committed data value or the tag of the in-flight operation that will produce that register's next value. An issue stage uses it once per instruction, in program order. Two source lookup ports report for each operand either "ready, here is the value" or "not ready, wait for this tag". A destination rename port then points the written register at the freshly allocated producer tag. Any older mapping of that register is simply replaced.

The table resolves pending registers on its own by listening to a single result broadcast bus that carries a (tag, value) pair. A pending register whose tag equals the broadcast tag takes the value in that cycle and becomes ready. A lookup made in the same cycle as the broadcast already sees the broadcast value. Tag value zero is reserved and means "no producer". The table performs no write-after-read or write-after-write checking, because giving every write a fresh tag makes those hazards impossible.

Top module: `rename_status_table`

## Requirements
- R1: When `ren_valid` is high, register `ren_idx` takes `ren_tag` as its pending producer tag at the next clock edge, and later lookups of it report that tag. `ren_tag` must be nonzero whenever `ren_valid` is high.
- R2: A lookup of a ready register returns ready = 1, the stored value, and tag 0.
- R3: A lookup of a pending register that is not matched by a broadcast in that cycle returns ready = 0, value 0, and the pending tag.
- R4: When `bus_valid` is high and `bus_tag` equals a register's pending tag, that register stores `bus_value` and becomes ready at that clock edge.
- R5: A broadcast whose tag is 0, or whose tag matches no pending register, changes no register. So does a cycle with `bus_valid` low.
- R6: If a rename and a matching broadcast target the same register in one cycle, the rename wins and the register stays pending on the new tag.
- R7: A lookup of a pending register in the same cycle as a matching broadcast returns ready = 1, `bus_value`, and tag 0.
- R8: Reset leaves every register ready with value 0 and tag 0.
- R9: Source lookups in a cycle that also renames return the mapping from before that rename, including when a source names the destination register.
- R10: The two lookup ports are independent and may name the same register.
- R11: Renaming a register that is already pending replaces its tag. A later broadcast of the replaced tag leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srca_idx | input | IDX_W | Register looked up by source port A |
| srca_ready | output | 1 | Port A operand is available |
| srca_value | output | DATA_W | Port A operand value (0 when pending) |
| srca_tag | output | TAG_W | Port A producer tag (0 when ready) |
| srcb_idx | input | IDX_W | Register looked up by source port B |
| srcb_ready | output | 1 | Port B operand is available |
| srcb_value | output | DATA_W | Port B operand value (0 when pending) |
| srcb_tag | output | TAG_W | Port B producer tag (0 when ready) |
| ren_valid | input | 1 | Rename the destination register this cycle |
| ren_idx | input | IDX_W | Destination register |
| ren_tag | input | TAG_W | Fresh producer tag, nonzero |
| bus_valid | input | 1 | Broadcast present this cycle |
| bus_tag | input | TAG_W | Broadcast producer tag |
| bus_value | input | DATA_W | Broadcast result value |

## Verification
The assertions rely on two properties of the inputs. The tag given on the rename port is never zero. A tag is not handed out again while any register still waits on it, so no two registers are ever pending on the same tag. The stimulus takes rename tags from a rotating counter over the nonzero values. It skips a rename whenever that counter lands on a tag some register still holds. Broadcasts use tags of pending registers, already replaced tags, zero, and arbitrary values, which covers the stale and no-match cases without breaking the assumption.

// File: rtl/rrst_pkg.sv
package rrst_pkg;
    localparam int unsigned RRST_NUM_REGS = 16;
    localparam int unsigned RRST_DATA_W   = 32;
    localparam int unsigned RRST_TAG_W    = 4;
endpackage

// File: rtl/rrst_entry.sv
module rrst_entry #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_sel,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic [TAG_W-1:0]  ent_tag,
    output logic [DATA_W-1:0] ent_value,
    output logic              bus_hit
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        bus_hit = bus_valid && (ent_q.tag != '0) && (bus_tag == ent_q.tag);
        ent_d   = ent_q;
        if (ren_sel) begin
            ent_d.tag = ren_tag;
        end else if (bus_hit) begin
            ent_d.tag   = '0;
            ent_d.value = bus_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ent_tag   = ent_q.tag;
    assign ent_value = ent_q.value;

    assert_rename_sets_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ren_sel |=> (ent_q.tag == $past(ren_tag)));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && !ren_sel) |=> (ent_q.tag == '0 && ent_q.value == $past(bus_value)));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit && !ren_sel) |=> $stable(ent_q));

    assert_rename_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && ren_sel) |=> (ent_q.tag != '0));

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (ent_q == '0));
endmodule

// File: rtl/rrst_read_port.sv
module rrst_read_port #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
    input  logic [NUM_REGS-1:0]              hits,
    input  logic [DATA_W-1:0]                bus_value,
    output logic                             rd_ready,
    output logic [DATA_W-1:0]                rd_value,
    output logic [TAG_W-1:0]                 rd_tag
);
    logic [TAG_W-1:0] sel_tag;

    always_comb begin
        sel_tag  = tags[rd_idx];
        rd_ready = 1'b1;
        rd_value = values[rd_idx];
        rd_tag   = '0;
        if (sel_tag != '0) begin
            if (hits[rd_idx]) begin
                rd_value = bus_value;
            end else begin
                rd_ready = 1'b0;
                rd_value = '0;
                rd_tag   = sel_tag;
            end
        end
    end

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tags[rd_idx] != '0 && hits[rd_idx]) |-> (rd_ready && rd_value == bus_value));

    assert_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tags[rd_idx] != '0 && !hits[rd_idx]) |-> (!rd_ready && rd_tag == tags[rd_idx]));

    assert_ready_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tags[rd_idx] == '0) |-> (rd_ready && rd_value == values[rd_idx]));
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
    parameter int unsigned NUM_REGS = rrst_pkg::RRST_NUM_REGS,
    parameter int unsigned DATA_W   = rrst_pkg::RRST_DATA_W,
    parameter int unsigned TAG_W    = rrst_pkg::RRST_TAG_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  srca_idx,
    output logic              srca_ready,
    output logic [DATA_W-1:0] srca_value,
    output logic [TAG_W-1:0]  srca_tag,
    input  logic [IDX_W-1:0]  srcb_idx,
    output logic              srcb_ready,
    output logic [DATA_W-1:0] srcb_value,
    output logic [TAG_W-1:0]  srcb_tag,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value
);
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr;
    logic [NUM_REGS-1:0][DATA_W-1:0] val_arr;
    logic [NUM_REGS-1:0]             hit_arr;
    logic [NUM_REGS-1:0]             sel_arr;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        assign sel_arr[gi] = ren_valid && (ren_idx == IDX_W'(gi));
        rrst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .ren_sel   (sel_arr[gi]),
            .ren_tag   (ren_tag),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_value (bus_value),
            .ent_tag   (tag_arr[gi]),
            .ent_value (val_arr[gi]),
            .bus_hit   (hit_arr[gi])
        );
    end

    rrst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .rd_idx(srca_idx), .tags(tag_arr), .values(val_arr),
        .hits(hit_arr), .bus_value(bus_value),
        .rd_ready(srca_ready), .rd_value(srca_value), .rd_tag(srca_tag)
    );

    rrst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .rd_idx(srcb_idx), .tags(tag_arr), .values(val_arr),
        .hits(hit_arr), .bus_value(bus_value),
        .rd_ready(srcb_ready), .rd_value(srcb_value), .rd_tag(srcb_tag)
    );

    assert_ren_tag_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid |-> (ren_tag != '0));

    assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_arr));

    assert_zero_tag_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tag == '0) |-> (hit_arr == '0));
endmodule

// File: tb/rename_status_table_bench.sv
`timescale 1ns/1ps
module rename_status_table_bench;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int TW   = 4;
    localparam int IW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IW-1:0] srca_idx = '0, srcb_idx = '0, ren_idx = '0;
    logic          srca_ready, srcb_ready;
    logic [DW-1:0] srca_value, srcb_value;
    logic [TW-1:0] srca_tag, srcb_tag;
    logic          ren_valid = 1'b0, bus_valid = 1'b0;
    logic [TW-1:0] ren_tag = '0, bus_tag = '0;
    logic [DW-1:0] bus_value = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [TW-1:0] m_tag [NREG];
    logic [DW-1:0] m_val [NREG];

    always #2.5 clk = ~clk;

    rename_status_table u_rename_status_table (
        .clk(clk), .rst_n(rst_n),
        .srca_idx(srca_idx), .srca_ready(srca_ready), .srca_value(srca_value), .srca_tag(srca_tag),
        .srcb_idx(srcb_idx), .srcb_ready(srcb_ready), .srcb_value(srcb_value), .srcb_tag(srcb_tag),
        .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_port(input string req, input string pname, input logic [IW-1:0] idx,
                              input logic rdy, input logic [DW-1:0] val, input logic [TW-1:0] tg);
        logic          e_rdy;
        logic [DW-1:0] e_val;
        logic [TW-1:0] e_tag;
        if (m_tag[idx] == '0) begin
            e_rdy = 1'b1; e_val = m_val[idx]; e_tag = '0;
        end else if (bus_valid && bus_tag == m_tag[idx]) begin
            e_rdy = 1'b1; e_val = bus_value; e_tag = '0;
        end else begin
            e_rdy = 1'b0; e_val = '0; e_tag = m_tag[idx];
        end
        chk(req, {pname, " ready"}, 64'(rdy), 64'(e_rdy));
        chk(req, {pname, " value"}, 64'(val), 64'(e_val));
        chk(req, {pname, " tag"},   64'(tg),  64'(e_tag));
    endtask

    task automatic model_update();
        for (int r = 0; r < NREG; r++) begin
            if (ren_valid && ren_idx == IW'(r)) begin
                m_tag[r] = ren_tag;
            end else if (bus_valid && m_tag[r] != '0 && bus_tag == m_tag[r]) begin
                m_tag[r] = '0;
                m_val[r] = bus_value;
            end
        end
    endtask

    task automatic step(input string req, input logic dv, input logic [IW-1:0] di, input logic [TW-1:0] dt,
                        input logic bv, input logic [TW-1:0] bt, input logic [DW-1:0] bval,
                        input logic [IW-1:0] sa, input logic [IW-1:0] sb);
        @(negedge clk);
        ren_valid = dv; ren_idx = di; ren_tag = dt;
        bus_valid = bv; bus_tag = bt; bus_value = bval;
        srca_idx = sa; srcb_idx = sb;
        #1;
        check_port(req, "portA", sa, srca_ready, srca_value, srca_tag);
        check_port(req, "portB", sb, srcb_ready, srcb_value, srcb_tag);
        model_update();
    endtask

    function automatic bit tag_in_use(input logic [TW-1:0] t);
        for (int r = 0; r < NREG; r++) if (m_tag[r] == t) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] next_tag;
        for (int r = 0; r < NREG; r++) begin m_tag[r] = '0; m_val[r] = '0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R8: reset state seen on both ports
        step("R8", 0, 0, 0, 0, 0, 0, 4'd0, 4'd15);
        step("R8", 0, 0, 0, 0, 0, 0, 4'd5, 4'd9);
        // R1, R9: rename r3 while reading r3 (old mapping)
        step("R1_R9", 1, 4'd3, 4'd5, 0, 0, 0, 4'd3, 4'd3);
        // R3, R9, R11: r3 pending on 5, rename again to 6
        step("R3_R9_R11", 1, 4'd3, 4'd6, 0, 0, 0, 4'd3, 4'd2);
        // R11: stale tag 5 broadcast ignored
        step("R11", 0, 0, 0, 1, 4'd5, 32'hDEAD0005, 4'd3, 4'd3);
        step("R11", 0, 0, 0, 0, 0, 0, 4'd3, 4'd0);
        // R7: bypass on matching broadcast
        step("R7", 0, 0, 0, 1, 4'd6, 32'hCAFE0006, 4'd3, 4'd1);
        // R4, R2, R10: captured value, same register on both ports
        step("R4_R2_R10", 0, 0, 0, 0, 0, 0, 4'd3, 4'd3);
        // R5: zero tag and non-matching tag broadcasts
        step("R5", 1, 4'd7, 4'd7, 1, 4'd0, 32'h11111111, 4'd3, 4'd7);
        step("R5", 0, 0, 0, 1, 4'd9, 32'h22222222, 4'd7, 4'd3);
        step("R5", 0, 0, 0, 0, 4'd7, 32'h33333333, 4'd7, 4'd3);
        // R6: rename and matching broadcast hit r7 together
        step("R6", 1, 4'd7, 4'd8, 1, 4'd7, 32'h44444444, 4'd7, 4'd7);
        step("R6", 0, 0, 0, 0, 0, 0, 4'd7, 4'd3);
        step("R4", 0, 0, 0, 1, 4'd8, 32'h55555555, 4'd0, 4'd7);
        step("R4", 0, 0, 0, 0, 0, 0, 4'd7, 4'd3);

        // mixed traffic compared every cycle against the model
        next_tag = 4'd1;
        for (int c = 0; c < 3000; c++) begin
            logic          dv, bv;
            logic [IW-1:0] di, sa, sb, pr;
            logic [TW-1:0] bt;
            dv = ($urandom_range(0, 2) != 0) && !tag_in_use(next_tag);
            di = IW'($urandom_range(0, NREG - 1));
            bv = ($urandom_range(0, 2) != 0);
            pr = IW'($urandom_range(0, NREG - 1));
            case ($urandom_range(0, 3))
                0, 1:    bt = m_tag[pr];
                2:       bt = TW'($urandom_range(0, (1 << TW) - 1));
                default: bt = '0;
            endcase
            sa = ($urandom_range(0, 3) == 0) ? di : IW'($urandom_range(0, NREG - 1));
            sb = ($urandom_range(0, 3) == 0) ? pr : IW'($urandom_range(0, NREG - 1));
            step("R1_R4_R7_R9_mixed", dv, di, next_tag, bv, bt, $urandom(), sa, sb);
            if (dv) next_tag = (next_tag == '1) ? 4'd1 : next_tag + 4'd1;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule